// File: doc/BRIEF.md
# Four-Channel Cascadable Reload Timer

A bank of four 16-bit up-counters sharing one small register port. Each channel advances either on a power-of-two division of the system clock or, when chained, on every overflow of the channel just below it. When a counter passes 0xFFFF it restarts from a programmed start value. It can also raise a one-cycle interrupt request on its own line.

Overflow pulses of channels 0 and 1 are exported, one cycle after the event, so that an audio sample engine can pace itself from them. Software programs the start value and a 16-bit control word per channel. It reads back the live count or the stored control word through a combinational read path.

Top module: `tmr_bank`

## Requirements
- R1: After reset every counter, start value and control word reads 0, and `irq_o` and `snd_ovf_o` are 0.
- R2: Address bits [2:1] pick the channel. Bit 0 = 0 selects the counter register and bit 0 = 1 selects the control register. Writing the counter register sets only the start value, not the live count. Reading it returns the live count. Reading the control register returns all 16 stored bits unchanged.
- R3: A control write that sets bit 7 (run) while the stored bit 7 is 0 loads the counter from the start value and clears the clock divider. With divide code 0, the count then rises by one on every following clock.
- R4: Control bits [1:0] choose the divide ratio: 0 means every clock, 1 means every 64, 2 means every 256 and 3 means every 1024. After the enabling write edge, the first increment comes exactly that many clocks later.
- R5: A counter at 0xFFFF that receives a count step reloads its start value, not zero.
- R6: A start-value write that lands on the same edge as an overflow does not affect that reload: the previous value is loaded. The new value is used from the next overflow on.
- R7: When control bit 6 is set, an overflow drives `irq_o[n]` high for exactly the one cycle after the overflow edge. Bit n feeds system interrupt index n+3. With bit 6 clear, the line stays low.
- R8: With control bit 2 set, channel n (n>0) ignores its divider and steps once per overflow of channel n-1. An overflow rippling through several chained channels completes on a single edge.
- R9: Channel 0 with bit 2 set never increments.
- R10: While bit 7 is 0, a channel holds its count and ignores both divider ticks and lower-channel overflows.
- R11: `snd_ovf_o[n]` for n = 0 and 1 pulses high for the cycle after each overflow of channel n, whatever the state of bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address: channel in [2:1], counter/control select in [0] |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data for `addr_i` |
| irq_o | output | 4 | Per-channel interrupt pulses, bit n = interrupt index n+3 |
| snd_ovf_o | output | 2 | Overflow pulses of channels 0 and 1 for the audio engine |

## Verification
Two events can coincide on one edge: a channel's own overflow reload, and an incoming cascade step that overflows the channels above it. The bench provokes this by parking channel 0 just below wrap and chaining two more channels at 0xFFFF. It then requires all of their interrupt and audio pulses, and the top channel's step, to show in the same sampled cycle. A second collision, a start-value write on the overflow edge itself, is judged by which value the counter holds after that edge and after the next wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DEF_NUM_CH = 4;
  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned DIV_W      = 10;
  localparam int unsigned DIV_CODE_W = 2;

  // control word field positions
  localparam int unsigned RUN_BIT  = 7;
  localparam int unsigned IE_BIT   = 6;
  localparam int unsigned CHAIN_BIT = 2;

  // low-bit mask of the divider that must be all ones for a tick
  function automatic logic [DIV_W-1:0] div_mask(input logic [DIV_CODE_W-1:0] code);
    logic [3:0] sh;
    sh = (code == '0) ? 4'd0 : (4'({code, 1'b0}) + 4'd4);
    return ~({DIV_W{1'b1}} << sh);
  endfunction
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider
  import tmr_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic [DIV_CODE_W-1:0] code_i,
  output logic                  tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask   = div_mask(code_i);
  assign tick_o = run_i && ((div_q & mask) == mask);

  // held at zero while stopped, so a fresh start always begins a full period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run_i) div_q <= '0;
    else             div_q <= div_q + {{(DIV_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cnt_i,
  input  logic             wr_ctl_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             chain_in_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ctl_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             ovf_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, reload_q, ctl_q;
  logic             irq_q;
  logic             run, chained, div_tick, step, start;

  assign run     = ctl_q[RUN_BIT];
  assign chained = ctl_q[CHAIN_BIT];

  tmr_divider u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .code_i (ctl_q[DIV_CODE_W-1:0]),
    .tick_o (div_tick)
  );

  assign step  = run && (chained ? chain_in_i : div_tick);
  assign ovf_o = step && (cnt_q == {CNT_W{1'b1}});
  assign start = wr_ctl_i && wdata_i[RUN_BIT] && !run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
      ctl_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (start || ovf_o) cnt_q <= reload_q;
      else if (step)      cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
      if (wr_cnt_i) reload_q <= wdata_i;
      if (wr_ctl_i) ctl_q    <= wdata_i;
      irq_q <= ovf_o && ctl_q[IE_BIT];
    end
  end

  assign cnt_o    = cnt_q;
  assign ctl_o    = ctl_q;
  assign reload_o = reload_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned SND_CH = 2,
  localparam int unsigned SEL_W = $clog2(NUM_CH),
  localparam int unsigned ADR_W = SEL_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADR_W-1:0]  addr_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic [SND_CH-1:0] snd_ovf_o
);
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_w, ctl_w, reload_w;
  logic [NUM_CH-1:0]            ovf_w;
  logic [SEL_W-1:0]             sel;
  logic [SND_CH-1:0]            snd_q;

  assign sel = addr_i[ADR_W-1:1];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ovf, chain_in, hit;
    assign hit = we_i && (sel == SEL_W'(i));
    if (i == 0) begin : g_first
      assign chain_in = 1'b0;
    end else begin : g_next
      assign chain_in = g_ch[i-1].ovf;
    end
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_cnt_i   (hit && !addr_i[0]),
      .wr_ctl_i   (hit && addr_i[0]),
      .wdata_i    (wdata_i),
      .chain_in_i (chain_in),
      .cnt_o      (cnt_w[i]),
      .ctl_o      (ctl_w[i]),
      .reload_o   (reload_w[i]),
      .ovf_o      (ovf),
      .irq_o      (irq_o[i])
    );
    assign ovf_w[i] = ovf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snd_q <= '0;
    else         snd_q <= ovf_w[SND_CH-1:0];
  end

  assign snd_ovf_o = snd_q;
  assign rdata_o   = addr_i[0] ? ctl_w[sel] : cnt_w[sel];
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned SND_CH = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [NUM_CH-1:0]            ovf_i,
  input logic [NUM_CH-1:0]            irq_i,
  input logic [SND_CH-1:0]            snd_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] ctl_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] reload_i
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_a
    AST_IRQ_AFTER_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_i[n] && ctl_i[n][IE_BIT]) |=> irq_i[n]); // R7
    AST_NO_STRAY_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ovf_i[n] && ctl_i[n][IE_BIT]) |=> !irq_i[n]); // R7
    AST_RELOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_i[n] |=> (cnt_i[n] == $past(reload_i[n]))); // R5
    AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctl_i[n][RUN_BIT] |=> (ctl_i[n][RUN_BIT] || $stable(cnt_i[n]))); // R10
  end
  for (genvar s = 0; s < SND_CH; s++) begin : g_s
    AST_SND_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_i[s] |=> snd_i[s]); // R11
    AST_SND_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ovf_i[s] |=> !snd_i[s]); // R11
  end
  AST_CH0_CHAIN_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i[0][CHAIN_BIT] && ctl_i[0][RUN_BIT]) |=> $stable(cnt_i[0])); // R9
endmodule

bind tmr_bank tmr_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .SND_CH(SND_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ovf_i    (ovf_w),
  .irq_i    (irq_o),
  .snd_i    (snd_ovf_o),
  .cnt_i    (cnt_w),
  .ctl_i    (ctl_w),
  .reload_i (reload_w)
);

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [3:0]  irq_o;
  logic [1:0]  snd_ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tmr_bank u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .snd_ovf_o(snd_ovf_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [1:0] ch, input bit ctl, input logic [15:0] d);
    addr_i = {ch, ctl}; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ch, input bit ctl, output logic [15:0] d);
    addr_i = {ch, ctl};
    #1 d = rdata_o;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int c = 0; c < 4; c++) begin
      rd(c[1:0], 1'b0, v); chk("R1 count", v, 16'h0);
      rd(c[1:0], 1'b1, v); chk("R1 control", v, 16'h0);
    end
    chk("R1 irq", {12'h0, irq_o}, 16'h0);
    chk("R1 snd", {14'h0, snd_ovf_o}, 16'h0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(2'd2, 1'b0, 16'h1234);
    rd(2'd2, 1'b0, v); chk("R2 start write leaves live count", v, 16'h0);
    wr(2'd2, 1'b1, 16'h0A78);
    rd(2'd2, 1'b1, v); chk("R2 control readback", v, 16'h0A78);
    step(5);
    rd(2'd2, 1'b0, v); chk("R10 stopped count", v, 16'h0);
    wr(2'd2, 1'b1, 16'h0000);
  endtask

  task automatic t_run();
    logic [15:0] v, hold;
    wr(2'd0, 1'b0, 16'h0100);
    wr(2'd0, 1'b1, 16'h0080);
    rd(2'd0, 1'b0, v); chk("R3 load on start", v, 16'h0100);
    step(5);
    rd(2'd0, 1'b0, v); chk("R3 count every clock", v, 16'h0105);
    wr(2'd0, 1'b1, 16'h0000);
    rd(2'd0, 1'b0, hold); chk("R3 last step on stop edge", hold, 16'h0106);
    step(10);
    rd(2'd0, 1'b0, v); chk("R10 hold while stopped", v, hold);
  endtask

  task automatic t_divide();
    logic [15:0] v;
    int ratio [4] = '{1, 64, 256, 1024};
    wr(2'd1, 1'b0, 16'h0000);
    for (int code = 1; code < 4; code++) begin
      wr(2'd1, 1'b1, 16'h0080 | 16'(code));
      step(ratio[code] - 1);
      rd(2'd1, 1'b0, v); chk($sformatf("R4 code %0d before tick", code), v, 16'h0);
      step(1);
      rd(2'd1, 1'b0, v); chk($sformatf("R4 code %0d first tick", code), v, 16'h1);
      wr(2'd1, 1'b1, 16'h0000);
    end
  endtask

  task automatic t_overflow();
    logic [15:0] v;
    wr(2'd0, 1'b0, 16'hFFFE);
    wr(2'd0, 1'b1, 16'h00C0);
    step(1);
    rd(2'd0, 1'b0, v); chk("R5 at top", v, 16'hFFFF);
    chk("R7 no irq before wrap", {12'h0, irq_o}, 16'h0);
    step(1);
    rd(2'd0, 1'b0, v); chk("R5 reload after wrap", v, 16'hFFFE);
    chk("R7 irq pulse ch0", {12'h0, irq_o}, 16'h0001);
    chk("R11 snd pulse ch0", {14'h0, snd_ovf_o}, 16'h0001);
    step(1);
    chk("R7 irq one cycle", {12'h0, irq_o}, 16'h0);
    chk("R11 snd one cycle", {14'h0, snd_ovf_o}, 16'h0);
    wr(2'd0, 1'b1, 16'h0000);
    // channel 1 without interrupt enable
    wr(2'd1, 1'b0, 16'hFFFF);
    wr(2'd1, 1'b1, 16'h0080);
    step(1);
    chk("R7 no irq when bit 6 clear", {12'h0, irq_o}, 16'h0);
    chk("R11 snd ch1 without irq enable", {14'h0, snd_ovf_o}, 16'h0002);
    wr(2'd1, 1'b1, 16'h0000);
  endtask

  task automatic t_reload_race();
    logic [15:0] v;
    wr(2'd2, 1'b0, 16'hFFFD);
    wr(2'd2, 1'b1, 16'h0080);
    step(2);
    rd(2'd2, 1'b0, v); chk("R6 at top before race", v, 16'hFFFF);
    wr(2'd2, 1'b0, 16'h1000);
    rd(2'd2, 1'b0, v); chk("R6 old start value on race edge", v, 16'hFFFD);
    step(3);
    rd(2'd2, 1'b0, v); chk("R6 new start value next wrap", v, 16'h1000);
    wr(2'd2, 1'b1, 16'h0000);
  endtask

  task automatic t_cascade();
    logic [15:0] v, hold;
    wr(2'd0, 1'b0, 16'hFFFE);
    wr(2'd1, 1'b0, 16'hFFFF);
    wr(2'd2, 1'b0, 16'hFFFF);
    wr(2'd3, 1'b0, 16'h0000);
    wr(2'd3, 1'b1, 16'h0084);
    wr(2'd2, 1'b1, 16'h00C4);
    wr(2'd1, 1'b1, 16'h00C4);
    step(3);
    rd(2'd1, 1'b0, v); chk("R8 chained ignores divider", v, 16'hFFFF);
    wr(2'd0, 1'b1, 16'h0080);
    step(1);
    chk("R8 no pulses before wrap", {12'h0, irq_o}, 16'h0);
    step(1);
    chk("R8 ripple irq same cycle", {12'h0, irq_o}, 16'h0006);
    chk("R8 ripple snd same cycle", {14'h0, snd_ovf_o}, 16'h0003);
    rd(2'd3, 1'b0, v); chk("R8 top channel stepped", v, 16'h0001);
    rd(2'd1, 1'b0, v); chk("R8 ch1 reloaded", v, 16'hFFFF);
    step(2);
    rd(2'd3, 1'b0, v); chk("R8 second ripple", v, 16'h0002);
    // stop ch1 while ch0 keeps wrapping
    wr(2'd1, 1'b1, 16'h0044);
    rd(2'd3, 1'b0, hold);
    step(6);
    rd(2'd3, 1'b0, v); chk("R10 no ripple past stopped ch1", v, hold);
    chk("R10 stopped ch1 irq quiet", {15'h0, irq_o[1]}, 16'h0);
    for (int c = 0; c < 4; c++) wr(c[1:0], 1'b1, 16'h0000);
  endtask

  task automatic t_ch0_chain();
    logic [15:0] v;
    wr(2'd0, 1'b0, 16'h0010);
    wr(2'd0, 1'b1, 16'h0084);
    step(20);
    rd(2'd0, 1'b0, v); chk("R9 ch0 chained frozen", v, 16'h0010);
    wr(2'd0, 1'b1, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_regs();
    t_run();
    t_divide();
    t_overflow();
    t_reload_race();
    t_cascade();
    t_ch0_chain();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule